// File: doc/BRIEF.md
# Byte and Bit Reordering Unit

This block is a 32-bit datapath slice. It reorders the bytes or bits of one operand, or counts the operand's leading zeros. A 3-bit operation code selects one of five functions:

- a reversal of all four bytes;
- a swap of the two bytes inside each halfword;
- a byte swap of the low halfword with sign extension;
- a mirror of all 32 bits;
- a leading-zero count.

The block is meant to sit beside an ALU in an execute stage. The caller presents an operand and a code together with `in_valid`. By default the answer comes back one clock later with `out_valid`.

A parameter can remove the output register. The unit is then purely combinational: the result follows the inputs in the same cycle and reads zero while `in_valid` is low. The leading-zero count is built as a log-depth tree of priority merges, not as a chain across the 32 bits.

Top module: `perm_unit`

## Requirements
- R1: Code 0 reverses byte order: operand bits 7:0 go to result bits 31:24, 15:8 to 23:16, 23:16 to 15:8 and 31:24 to 7:0.
- R2: Code 1 exchanges bits 15:8 with bits 7:0 and bits 31:24 with bits 23:16. Each byte stays inside its own halfword.
- R3: Code 2 takes only operand bits 15:0 and swaps their two bytes. It then fills result bits 31:16 with copies of result bit 15. Operand bits 31:16 have no effect.
- R4: Code 3 places operand bit i at result bit 31-i, for every i from 0 to 31.
- R5: Code 4 returns the number of zero bits above the highest set bit, which is 31 minus that bit's index. An all-zero operand returns 32. Result bits 31:6 are always zero.
- R6: Codes 5, 6 and 7 return a result of zero.
- R7: With the output register present (default), `result` and `out_valid` reflect the inputs sampled at the rising edge where `in_valid` is high, and appear exactly one clock later. `out_valid` is low one clock after an edge where `in_valid` was low.
- R8: During and just after reset (`rst_n` low), `result` is zero and `out_valid` is low.
- R9: With the output register present, `result` keeps its last value while `in_valid` is low, whatever the operand and code inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and code are valid this cycle |
| opcode | input | 3 | Operation select: 0 byte reverse, 1 halfword swap, 2 signed swap, 3 bit mirror, 4 leading zeros, 5 to 7 zero |
| operand | input | 32 | Source value |
| result | output | 32 | Computed value |
| out_valid | output | 1 | Result is valid |

## Verification
The bench targets the values where each function can go wrong quietly: zero, all-ones, only the top bit set and only the bottom bit set, plus random operands for every code. A leading-zero tree with a wrong merge order or a missing zero rule returns 0 or 31 instead of 32 for zero, and a wrong count for a lone top or bottom bit. A signed swap that extends from the wrong bit, or that lets operand bits 31:16 through, fails on 0x00000080 against 0xFFFF0000. A mirror or reverse with a crossed lane is caught by the asymmetric random patterns. Codes 5 to 7, the one-cycle latency and the hold of the result while `in_valid` is low are each driven and observed at the ports.

// File: rtl/perm_pkg.sv
package perm_pkg;
    localparam int DW      = 32;
    localparam int NBYTES  = DW / 8;
    localparam int LZ_LVLS = $clog2(DW);
    localparam int LZ_W    = LZ_LVLS + 1;

    typedef enum logic [2:0] {
        OP_BREV  = 3'd0,
        OP_HSWAP = 3'd1,
        OP_SSWAP = 3'd2,
        OP_BITM  = 3'd3,
        OP_LZC   = 3'd4
    } op_e;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } out_t;
endpackage

// File: rtl/byte_lane_perm.sv
module byte_lane_perm
    import perm_pkg::*;
(
    input  logic [DW-1:0] src,
    output logic [DW-1:0] rev_all,
    output logic [DW-1:0] rev_half,
    output logic [DW-1:0] rev_sext
);
    for (genvar b = 0; b < NBYTES; b++) begin : gen_rev
        assign rev_all[8*b +: 8] = src[8*(NBYTES-1-b) +: 8];
    end

    for (genvar h = 0; h < NBYTES/2; h++) begin : gen_half
        assign rev_half[16*h +: 8]     = src[16*h+8 +: 8];
        assign rev_half[16*h+8 +: 8]   = src[16*h +: 8];
    end

    assign rev_sext = {{(DW-16){src[7]}}, src[7:0], src[15:8]};
endmodule

// File: rtl/bit_mirror.sv
module bit_mirror
    import perm_pkg::*;
(
    input  logic [DW-1:0] src,
    output logic [DW-1:0] dst
);
    for (genvar i = 0; i < DW; i++) begin : gen_bit
        assign dst[i] = src[DW-1-i];
    end
endmodule

// File: rtl/lzc_tree.sv
module lzc_tree
    import perm_pkg::*;
(
    input  logic [DW-1:0]   src,
    output logic [LZ_W-1:0] count
);
    // Level l has DW>>l nodes; each node covers 2**l bits and holds
    // "any bit set" plus the zero count above its first set bit.
    for (genvar l = 1; l <= LZ_LVLS; l++) begin : gen_lvl
        localparam int NN = DW >> l;
        logic [NN-1:0] any_v;
        logic [l-1:0]  cnt_v [NN];
        for (genvar j = 0; j < NN; j++) begin : gen_node
            if (l == 1) begin : gen_leaf
                assign any_v[j] = src[2*j+1] | src[2*j];
                assign cnt_v[j] = ~src[2*j+1];
            end else begin : gen_merge
                assign any_v[j] = gen_lvl[l-1].any_v[2*j+1] | gen_lvl[l-1].any_v[2*j];
                assign cnt_v[j] = gen_lvl[l-1].any_v[2*j+1]
                                ? {1'b0, gen_lvl[l-1].cnt_v[2*j+1]}
                                : {1'b1, gen_lvl[l-1].cnt_v[2*j]};
            end
        end
    end

    assign count = gen_lvl[LZ_LVLS].any_v[0] ? {1'b0, gen_lvl[LZ_LVLS].cnt_v[0]}
                                             : LZ_W'(DW);
endmodule

// File: rtl/perm_unit.sv
module perm_unit
    import perm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    opcode,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result,
    output logic          out_valid
);
    logic [DW-1:0]   r_all, r_half, r_sext, r_mir;
    logic [LZ_W-1:0] r_lz;
    logic [DW-1:0]   sel_res;
    logic [DW-1:0]   held;
    out_t            out_d, out_q;

    byte_lane_perm u_bytes (.src(operand), .rev_all(r_all), .rev_half(r_half), .rev_sext(r_sext));
    bit_mirror     u_mirror(.src(operand), .dst(r_mir));
    lzc_tree       u_lzc   (.src(operand), .count(r_lz));

    always_comb begin
        case (op_e'(opcode))
            OP_BREV:  sel_res = r_all;
            OP_HSWAP: sel_res = r_half;
            OP_SSWAP: sel_res = r_sext;
            OP_BITM:  sel_res = r_mir;
            OP_LZC:   sel_res = {{(DW-LZ_W){1'b0}}, r_lz};
            default:  sel_res = '0;
        endcase
    end

    always_comb begin
        out_d.vld  = in_valid;
        out_d.data = in_valid ? sel_res : held;
    end

    if (REG_OUT) begin : gen_reg
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= out_d;
        end
        assign held = out_q.data;

        assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(result));
        assert_unused_codes_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode > 3'd4) |=> (result == '0));
        assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == 3'd4 && operand == '0) |=> (result == DW));
        assert_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == 3'd2) |=> (result[DW-1:16] == {(DW-16){result[15]}}));
        assert_mirror_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == 3'd3) |=> ($countones(result) == $countones($past(operand))));
        assert_brev_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == 3'd0) |=> ($countones(result) == $countones($past(operand))));
    end else begin : gen_comb
        assign held  = '0;
        assign out_q = out_d;
    end

    assign result    = out_q.data;
    assign out_valid = out_q.vld;
endmodule

// File: tb/sim_perm_unit.sv
`timescale 1ns/1ps
module sim_perm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] operand = '0;
    logic [31:0] result;
    logic        out_valid;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic [34:0] exp_q [$];   // {op, expected}
    logic [31:0] last_exp;

    always #4 clk = ~clk;

    perm_unit u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
                  .operand(operand), .result(result), .out_valid(out_valid));

    function automatic logic [31:0] ref_calc(input logic [2:0] op, input logic [31:0] x);
        logic [31:0] r;
        int n;
        r = '0;
        case (op)
            3'd0: r = {x[7:0], x[15:8], x[23:16], x[31:24]};
            3'd1: r = {x[23:16], x[31:24], x[7:0], x[15:8]};
            3'd2: begin r[15:0] = {x[7:0], x[15:8]}; r[31:16] = {16{x[7]}}; end
            3'd3: for (int i = 0; i < 32; i++) r[31-i] = x[i];
            3'd4: begin
                n = 32;
                for (int i = 0; i < 32; i++) if (x[i]) n = 31 - i;
                r = 32'(n);
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3";
            3'd3: return "R4"; 3'd4: return "R5"; default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [2:0] op, input logic [31:0] x);
        @(negedge clk);
        in_valid = 1'b1;
        opcode   = op;
        operand  = x;
        exp_q.push_back({op, ref_calc(op, x)});
        last_exp = ref_calc(op, x);
    endtask

    // monitor: one result per valid input, one clock later (R7)
    always @(negedge clk) begin
        logic [34:0] it;
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                it = exp_q.pop_front();
                check(tag(it[34:32]), result, it[31:0]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] corners [4];
        corners[0] = 32'h0; corners[1] = 32'hFFFF_FFFF;
        corners[2] = 32'h8000_0000; corners[3] = 32'h0000_0001;

        repeat (3) @(negedge clk);
        check("R8 result in reset", result, 32'h0);
        check("R8 valid in reset", {31'b0, out_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 valid after reset", {31'b0, out_valid}, 32'h0);

        for (int op = 0; op < 8; op++)
            for (int c = 0; c < 4; c++) send(3'(op), corners[c]);
        send(3'd2, 32'h0000_0080);   // R3 sign from bit 7
        send(3'd2, 32'hFFFF_0000);   // R3 upper half ignored
        send(3'd4, 32'h0001_0000);   // R5 mid-range count
        for (int k = 0; k < 60; k++)
            for (int op = 0; op < 8; op++) send(3'(op), $urandom);

        // R9 hold: after a last valid item, vary inputs with in_valid low
        send(3'd3, 32'h1234_5678);
        @(negedge clk);
        in_valid = 1'b0; opcode = 3'd0; operand = 32'hDEAD_BEEF;
        @(negedge clk);
        operand = 32'h0F0F_0F0F; opcode = 3'd4;
        repeat (2) @(negedge clk);
        check("R9 result held", result, last_exp);
        check("R7 valid low when idle", {31'b0, out_valid}, 32'h0);
        check("R7 all results delivered", 32'(exp_q.size()), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule